// File: doc/BRIEF.md
# Channel Power Configuration Register File

This block holds the device configuration for a two-channel receive device. A small parallel write port loads one of eight 7-bit banks, selected by a 3-bit address, on every rising clock edge while an active-low write strobe is held low. The banks can only be written; they return no data. Each channel owns three banks: two hold settings that rarely change, and one holds settings that may be changed while the device runs. Two further banks are internal test registers.

From the stored bits the block drives per-channel power controls. These cover the receive PLL enable, the two serial output driver enables, the two reclocking driver enables, and three derived enables: the channel's internal logic, the reclock function, and the deserializer. Reset loads fixed values that leave every receive channel disabled, so software must enable each channel through the write port before using it. The asynchronous active-low reset is released synchronously, two clock edges after `rst_n` rises.

Top module: `cfgl_top`

## Requirements
- R1: While `wr_n` is low at a rising clock edge, `wdata` is stored into bank `addr`. Bank addresses are fixed: channel 0 owns addresses 0 (static bank S0), 1 (static bank S1) and 2 (dynamic bank). Channel 1 owns 5 (S0), 6 (S1) and 7 (dynamic). Addresses 3 and 4 are test banks.
- R2: While reset is asserted, and after it is released with no writes, every output is 0. Asserting `rst_n` low clears the banks at once, without waiting for a clock.
- R3: In a channel's dynamic bank, bit 0 drives `rx_pll_en[c]`, where 1 enables the receive PLL and 0 disables it. Bit 1 drives `tx_drv_en[2c]`, which enables driver 1. Bit 2 drives `tx_drv_en[2c+1]`, which enables driver 2.
- R4: In a channel's S1 bank, bit 0 drives `rck_drv_en[2c]` (reclock driver 1) and bit 1 drives `rck_drv_en[2c+1]` (reclock driver 2).
- R5: `core_pwr_en[c]` is 0 exactly when both serial output drivers of channel c are disabled.
- R6: `reclock_en[c]` is 0 exactly when both reclock drivers of channel c are disabled. `deser_en[c]` equals `rx_pll_en[c]` and is not affected by the reclock drivers.
- R7: While `wr_n` is high, no bank changes and no output changes.
- R8: While `wr_n` is held low across several clock edges, the data present at each edge is stored, once per edge.
- R9: Writes to the test banks (3, 4), to the S0 banks (0, 5), or to bits that no field uses (dynamic bits 6:3, S1 bits 6:2) change no output.
- R10: Writes to one channel's banks leave the other channel's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 3 | Bank address |
| wdata | input | 7 | Write data |
| rx_pll_en | output | 2 | Receive PLL and analog enable, one bit per channel |
| tx_drv_en | output | 4 | Serial driver enables, two bits per channel |
| rck_drv_en | output | 4 | Reclock driver enables, two bits per channel |
| core_pwr_en | output | 2 | Channel internal logic power enable |
| reclock_en | output | 2 | Reclock function enable |
| deser_en | output | 2 | Deserializer and parallel output enable |

## Verification
The assertions assume that `addr` and `wdata` are settled and known whenever `wr_n` is low at a clock edge. They also assume that no write is attempted while the internal reset is still held during its synchronous release. The bench drives every input on the falling clock edge, or one nanosecond after a rising edge, so values are always stable at the sampling edge. It issues its first write only several cycles after `rst_n` rises. Every write is a full, known bank value, which lets the bench keep an exact copy of all eight banks.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  localparam int unsigned CFG_DW   = 7;
  localparam int unsigned CFG_AW   = 3;
  localparam int unsigned NUM_CH   = 2;
  // bank offsets inside a channel group
  localparam int unsigned OFS_S0   = 0;
  localparam int unsigned OFS_S1   = 1;
  localparam int unsigned OFS_DYN  = 2;
  // field positions
  localparam int unsigned BIT_PLL  = 0;
  localparam int unsigned BIT_OE1  = 1;
  localparam int unsigned BIT_OE2  = 2;
  localparam int unsigned BIT_ROE1 = 0;
  localparam int unsigned BIT_ROE2 = 1;

  function automatic int unsigned ch_base(input int unsigned ch);
    return (ch == 0) ? 0 : 5;
  endfunction

  typedef struct packed {
    logic       pll_en;
    logic [1:0] drv;
    logic [1:0] rck;
  } ch_pwr_t;
endpackage

// File: rtl/cfgl_addr_dec.sv
module cfgl_addr_dec #(
  parameter int unsigned ADDR_W = 3,
  localparam int unsigned NB    = 1 << ADDR_W
) (
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  output logic [NB-1:0]     bank_we
);
  always_comb begin
    bank_we = '0;
    for (int i = 0; i < NB; i++) begin
      if (!wr_n && (addr == ADDR_W'(i))) bank_we[i] = 1'b1;
    end
  end
endmodule

// File: rtl/cfgl_bank.sv
module cfgl_bank #(
  parameter int unsigned      W   = 7,
  parameter logic [W-1:0]     RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_q, q_nxt;

  always_comb begin
    q_nxt = q_q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= RST;
    else        q_q <= q_nxt;
  end

  assign q = q_q;
endmodule

// File: rtl/cfgl_pwr_map.sv
module cfgl_pwr_map
  import cfgl_pkg::*;
#(
  parameter int unsigned W = 7
) (
  input  logic [W-1:0] dyn_bank,
  input  logic [W-1:0] s1_bank,
  output ch_pwr_t      pwr,
  output logic         core_en,
  output logic         rclk_en,
  output logic         dser_en
);
  always_comb begin
    pwr.pll_en = dyn_bank[BIT_PLL];
    pwr.drv    = {dyn_bank[BIT_OE2], dyn_bank[BIT_OE1]};
    pwr.rck    = {s1_bank[BIT_ROE2], s1_bank[BIT_ROE1]};
    // logic powers down only when both serial drivers are off
    core_en    = |pwr.drv;
    // reclock turns off with both reclock drivers; deserializer follows PLL only
    rclk_en    = |pwr.rck;
    dser_en    = pwr.pll_en;
  end
endmodule

// File: rtl/cfgl_top.sv
module cfgl_top
  import cfgl_pkg::*;
#(
  parameter int unsigned DATA_W = CFG_DW,
  parameter int unsigned ADDR_W = CFG_AW,
  parameter int unsigned N_CH   = NUM_CH,
  localparam int unsigned NB    = 1 << ADDR_W,
  parameter logic [NB*DATA_W-1:0] RST_VALS = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [N_CH-1:0]   rx_pll_en,
  output logic [2*N_CH-1:0] tx_drv_en,
  output logic [2*N_CH-1:0] rck_drv_en,
  output logic [N_CH-1:0]   core_pwr_en,
  output logic [N_CH-1:0]   reclock_en,
  output logic [N_CH-1:0]   deser_en
);
  // reset: asserted asynchronously, released after two edges
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NB-1:0]     bank_we;
  logic [DATA_W-1:0] bank_q [NB];

  cfgl_addr_dec #(.ADDR_W(ADDR_W)) dec_i (
    .wr_n    (wr_n),
    .addr    (addr),
    .bank_we (bank_we)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    cfgl_bank #(.W(DATA_W), .RST(RST_VALS[b*DATA_W +: DATA_W])) bank_i (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .we    (bank_we[b]),
      .d     (wdata),
      .q     (bank_q[b])
    );
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned BASE = ch_base(c);
    ch_pwr_t pwr;
    cfgl_pwr_map #(.W(DATA_W)) map_i (
      .dyn_bank (bank_q[BASE + OFS_DYN]),
      .s1_bank  (bank_q[BASE + OFS_S1]),
      .pwr      (pwr),
      .core_en  (core_pwr_en[c]),
      .rclk_en  (reclock_en[c]),
      .dser_en  (deser_en[c])
    );
    assign rx_pll_en[c]        = pwr.pll_en;
    assign tx_drv_en[2*c +: 2] = pwr.drv;
    assign rck_drv_en[2*c +: 2] = pwr.rck;
  end
endmodule

// File: rtl/cfgl_top_chk.sv
module cfgl_top_chk
  import cfgl_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic       wr_n,
  input logic [2:0] addr,
  input logic [6:0] wdata,
  input logic [1:0] rx_pll_en,
  input logic [3:0] tx_drv_en,
  input logic [3:0] rck_drv_en,
  input logic [1:0] core_pwr_en,
  input logic [1:0] reclock_en,
  input logic [1:0] deser_en
);
  logic [15:0] outs;
  assign outs = {rx_pll_en, tx_drv_en, rck_drv_en, core_pwr_en, reclock_en, deser_en};

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_n |=> $stable(outs));

  // R9
  dead_bank_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_n && (addr == 3'd0 || addr == 3'd3 || addr == 3'd4 || addr == 3'd5)) |=> $stable(outs));

  for (genvar c = 0; c < 2; c++) begin : g_c
    localparam logic [2:0] DYN = 3'(ch_base(c) + OFS_DYN);
    localparam logic [2:0] S1  = 3'(ch_base(c) + OFS_S1);

    // R3
    pll_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!wr_n && addr == DYN) |=> rx_pll_en[c] == $past(wdata[BIT_PLL]));

    // R5
    core_off_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $fell(core_pwr_en[c]) |-> tx_drv_en[2*c +: 2] == 2'b00);

    // R6
    deser_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!wr_n && addr == S1) |=> ($stable(deser_en) && $stable(rx_pll_en)));

    // R10
    other_ch_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (!wr_n && (addr == DYN || addr == S1)) |=>
        ($stable(rx_pll_en[1-c]) && $stable(tx_drv_en[2*(1-c) +: 2]) &&
         $stable(rck_drv_en[2*(1-c) +: 2])));
  end
endmodule

bind cfgl_top cfgl_top_chk chk_i (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .wr_n        (wr_n),
  .addr        (addr),
  .wdata       (wdata),
  .rx_pll_en   (rx_pll_en),
  .tx_drv_en   (tx_drv_en),
  .rck_drv_en  (rck_drv_en),
  .core_pwr_en (core_pwr_en),
  .reclock_en  (reclock_en),
  .deser_en    (deser_en)
);

// File: tb/cfgl_top_tb_top.sv
module cfgl_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_n;
  logic [2:0] addr;
  logic [6:0] wdata;
  logic [1:0] rx_pll_en, core_pwr_en, reclock_en, deser_en;
  logic [3:0] tx_drv_en, rck_drv_en;

  int checks = 0;
  int errors = 0;
  logic [6:0] mdl [8];

  always #10 clk = ~clk;

  cfgl_top dut_i (
    .clk (clk), .rst_n (rst_n), .wr_n (wr_n), .addr (addr), .wdata (wdata),
    .rx_pll_en (rx_pll_en), .tx_drv_en (tx_drv_en), .rck_drv_en (rck_drv_en),
    .core_pwr_en (core_pwr_en), .reclock_en (reclock_en), .deser_en (deser_en)
  );

  function automatic logic [15:0] expect_vec();
    logic [1:0] pll, core, rcl;
    logic [3:0] drv, rck;
    for (int c = 0; c < 2; c++) begin
      int b = (c == 0) ? 0 : 5;
      pll[c]         = mdl[b+2][0];
      drv[2*c +: 2]  = mdl[b+2][2:1];
      rck[2*c +: 2]  = mdl[b+1][1:0];
      core[c]        = |mdl[b+2][2:1];
      rcl[c]         = |mdl[b+1][1:0];
    end
    return {pll, drv, rck, core, rcl, pll};
  endfunction

  function automatic logic [15:0] actual_vec();
    return {rx_pll_en, tx_drv_en, rck_drv_en, core_pwr_en, reclock_en, deser_en};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [6:0] d);
    @(negedge clk);
    wr_n = 1'b0; addr = a; wdata = d;
    @(posedge clk); #1;
    wr_n = 1'b1;
    mdl[a] = d;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    // R2: cleared asynchronously
    check("R2", actual_vec(), 16'h0000);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    check("R2", actual_vec(), 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    wr_n = 1'b1; addr = '0; wdata = '0;
    do_reset();

    // R1: each channel bank at its own address
    wr(3'd2, 7'b0000111);
    check("R1", actual_vec(), expect_vec());
    wr(3'd6, 7'b0000010);
    check("R1", actual_vec(), expect_vec());

    // R5: one driver on keeps logic powered; both off powers it down
    wr(3'd2, 7'b0000011);
    check("R5", {15'd0, core_pwr_en[0]}, 16'd1);
    wr(3'd2, 7'b0000001);
    check("R5", {15'd0, core_pwr_en[0]}, 16'd0);

    // R6: reclock off with both drivers off, deserializer untouched
    wr(3'd7, 7'b0000001);
    wr(3'd6, 7'b0000011);
    check("R6", {14'd0, reclock_en[1], deser_en[1]}, 16'd3);
    wr(3'd6, 7'b0000000);
    check("R6", {14'd0, reclock_en[1], deser_en[1]}, 16'd1);

    // R10: channel 0 write, channel 1 outputs unchanged
    wr(3'd2, 7'b0000110);
    check("R10", actual_vec(), expect_vec());

    // R7: strobe high, other inputs moving
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      addr = 3'(i); wdata = 7'(i * 37);
      @(posedge clk); #1;
      check("R7", actual_vec(), expect_vec());
    end

    // R8: strobe held low, new data every edge
    @(negedge clk);
    wr_n = 1'b0; addr = 3'd2; wdata = 7'b0000001;
    @(posedge clk); #1;
    check("R8", {15'd0, rx_pll_en[0]}, 16'd1);
    wdata = 7'b0000000;
    @(posedge clk); #1;
    check("R8", {15'd0, rx_pll_en[0]}, 16'd0);
    wdata = 7'b0000101;
    @(posedge clk); #1;
    wr_n = 1'b1;
    mdl[2] = 7'b0000101;
    check("R8", actual_vec(), expect_vec());

    // exhaustive sweep of every address and data value
    for (int a = 0; a < 8; a++) begin
      for (int d = 0; d < 128; d++) begin
        wr(3'(a), 7'(d));
        if (a == 0 || a == 3 || a == 4 || a == 5) tag = "R9";
        else if (a == 2 || a == 7)                 tag = "R3";
        else                                       tag = "R4";
        check(tag, actual_vec(), expect_vec());
      end
    end

    // R2: reset mid-run after writes
    wr(3'd7, 7'b0000111);
    do_reset();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule